// File: doc/BRIEF.md
# MSI Doorbell Status Register Bank

This block collects message-signalled interrupts that arrive as a single data write to a doorbell register. It turns each write into one pending bit in a bank of 32-bit status words. The doorbell data word holds two fields. The low `SHIFT` bits pick the status word. The bits above them give the interrupt position inside that word. Positions are stored in reversed bit order, so position 0 lands in the most significant bit of its slice.

Each status word drives its own level interrupt line. Software reads a status word to collect its pending bits, and the read clears them. Read data is presented byte-reversed, so the word appears big-endian on the bus. The `NARROW` parameter selects a second layout. In that layout each word carries only eight sources, placed in a byte slice that depends on the word index, and the words sit at a higher base offset.

Top module: `msi_doorbell_bank`

## Requirements
- R1: While `rst_n` is low, every status word is cleared and every `irq` bit is 0. `rd_data` is 0 after reset.
- R2: A write with `wr_en=1` and `wr_addr=0` is a doorbell. Register n = `wr_data[SHIFT-1:0]`. Position p = `wr_data >> SHIFT`. In the default layout this sets bit (31-p) of register n.
- R3: A doorbell is ignored when p is at least the per-register source count (32 by default, 8 in the narrow layout), or when n is not below the number of implemented registers. Only 4 registers exist in the narrow layout. An ignored doorbell changes no status bit and no `irq` bit.
- R4: Register n is read at byte offset BASE+4n, with BASE = 0x4 by default and 0x10 in the narrow layout. `rd_data` updates on the clock edge that samples `rd_en=1`. The value is byte-reversed: register bits [31:24] appear in `rd_data[7:0]` and register bits [7:0] appear in `rd_data[31:24]`.
- R5: A read of a status register returns its pending bits and clears them, so a second read returns 0.
- R6: If a doorbell sets a bit in a register in the same cycle that the register is read, the returned data excludes the new bit and the new bit stays pending.
- R7: `irq[n]` is 1 exactly when status register n is nonzero. It rises on the edge that stores a doorbell and falls on the edge of the clearing read.
- R8: In the narrow layout, position p of register n sets bit (31 - 8n - p).
- R9: Successive doorbells accumulate as an OR within a register and never disturb other registers.
- R10: Writes to any address other than 0 have no effect. Reads of address 0, of unaligned addresses, and of addresses past the last register return 0 and clear nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write byte address; only 0 (doorbell) is accepted |
| wr_data | input | 32 | Doorbell data word: register select in the low bits, position above |
| rd_en | input | 1 | Read strobe; a hit clears the addressed register |
| rd_addr | input | AW | Read byte address |
| rd_data | output | 32 | Byte-reversed read data, registered |
| irq | output | 2**SHIFT | Level interrupt, one per status register |

## Verification
The default layout is driven with doorbells at the lowest and highest positions. Those two cases separate reversed bit order from direct order and catch byte-swap mistakes on readback. Doorbells to two registers in turn show that the select field and the position field are split at the right bit and that registers stay independent. Out-of-range positions, stray write addresses and odd read addresses show that nothing leaks into the bank. A doorbell that lands in the same cycle as a read tells a set-wins merge apart from a clear-wins merge. A second instance in the narrow layout checks the per-register slice placement and the higher base offset.

// File: rtl/msi_bank_pkg.sv
package msi_bank_pkg;

  // Number of interrupt sources held by one status word.
  function automatic int unsigned per_reg(bit narrow);
    return narrow ? 8 : 32;
  endfunction

  // Status words actually implemented: the narrow layout packs at most four.
  function automatic int unsigned used_regs(int unsigned shift, bit narrow);
    int unsigned n;
    n = 1 << shift;
    return (narrow && n > 4) ? 4 : n;
  endfunction

  // Byte offset of status word 0.
  function automatic int unsigned status_base(bit narrow);
    return narrow ? 16 : 4;
  endfunction

  // Register bit that stores position pos of word reg_n (reversed order).
  function automatic int unsigned slot_bit(bit narrow, int unsigned reg_n,
                                           int unsigned pos);
    if (narrow) return 31 - 8 * reg_n - pos;
    return 31 - pos;
  endfunction

  // Big-endian presentation of a 32-bit word on the read bus.
  function automatic logic [31:0] be_word(logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

endpackage

// File: rtl/msi_db_decode.sv
module msi_db_decode
  import msi_bank_pkg::*;
#(
  parameter int SHIFT  = 3,
  parameter bit NARROW = 1'b0,
  parameter int AW     = 8,
  localparam int NREG  = 1 << SHIFT
) (
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [31:0]     wr_data,
  output logic [NREG-1:0] set_oh,
  output logic [4:0]      set_bit
);
  localparam int NUSED = int'(used_regs(SHIFT, NARROW));
  localparam logic [31-SHIFT:0] POS_LIM = (32-SHIFT)'(per_reg(NARROW));
  localparam logic [SHIFT:0]    SEL_LIM = (SHIFT+1)'(NUSED);

  logic [SHIFT-1:0]  sel;
  logic [31-SHIFT:0] pos;
  logic              hit;

  always_comb begin
    sel     = wr_data[SHIFT-1:0];
    pos     = wr_data[31:SHIFT];
    hit     = wr_en && (wr_addr == '0) && (pos < POS_LIM) && ({1'b0, sel} < SEL_LIM);
    set_oh  = hit ? (NREG'(1) << sel) : '0;
    set_bit = 5'(slot_bit(NARROW, 32'(sel), 32'(pos[4:0])));
  end
endmodule

// File: rtl/msi_status_word.sv
module msi_status_word (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_en,
  input  logic [4:0]  set_bit,
  input  logic        clr_en,
  output logic [31:0] word
);
  logic [31:0] set_mask;
  logic [31:0] word_nx;

  always_comb begin
    set_mask = set_en ? (32'd1 << set_bit) : '0;
    // set wins over a clearing read in the same cycle
    word_nx  = (clr_en ? 32'd0 : word) | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word <= '0;
    else        word <= word_nx;
  end
endmodule

// File: rtl/msi_rd_port.sv
module msi_rd_port
  import msi_bank_pkg::*;
#(
  parameter int SHIFT  = 3,
  parameter bit NARROW = 1'b0,
  parameter int AW     = 8,
  localparam int NREG  = 1 << SHIFT
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_en,
  input  logic [AW-1:0]         rd_addr,
  input  logic [NREG-1:0][31:0] words,
  output logic                  rd_hit,
  output logic [NREG-1:0]       clr_oh,
  output logic [31:0]           rd_data
);
  localparam int NUSED = int'(used_regs(SHIFT, NARROW));
  localparam logic [AW-1:0] BASE_A = AW'(status_base(NARROW));
  localparam logic [AW-3:0] NU_A   = (AW-2)'(NUSED);

  logic [AW-1:0]    off;
  logic [SHIFT-1:0] idx;

  always_comb begin
    off    = rd_addr - BASE_A;
    idx    = off[SHIFT+1:2];
    rd_hit = rd_en && (rd_addr >= BASE_A) && (off[1:0] == 2'b00) && (off[AW-1:2] < NU_A);
    clr_oh = rd_hit ? (NREG'(1) << idx) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_hit ? be_word(words[idx]) : 32'd0;
  end
endmodule

// File: rtl/msi_doorbell_bank.sv
module msi_doorbell_bank
  import msi_bank_pkg::*;
#(
  parameter int SHIFT  = 3,
  parameter bit NARROW = 1'b0,
  parameter int AW     = 8,
  localparam int NREG  = 1 << SHIFT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [31:0]     wr_data,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  output logic [31:0]     rd_data,
  output logic [NREG-1:0] irq
);
  localparam int NUSED = int'(used_regs(SHIFT, NARROW));

  // named internal events, observed by the bound checker
  logic [NREG-1:0]       db_set_oh;
  logic [4:0]            db_set_bit;
  logic [NREG-1:0]       rd_clr_oh;
  logic                  rd_hit;
  logic [NREG-1:0][31:0] words;

  msi_db_decode #(.SHIFT(SHIFT), .NARROW(NARROW), .AW(AW)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .set_oh  (db_set_oh),
    .set_bit (db_set_bit)
  );

  for (genvar n = 0; n < NREG; n++) begin : g_reg
    if (n < NUSED) begin : g_live
      msi_status_word u_word (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (db_set_oh[n]),
        .set_bit (db_set_bit),
        .clr_en  (rd_clr_oh[n]),
        .word    (words[n])
      );
    end else begin : g_absent
      assign words[n] = '0;
    end
    assign irq[n] = |words[n];
  end

  msi_rd_port #(.SHIFT(SHIFT), .NARROW(NARROW), .AW(AW)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .words   (words),
    .rd_hit  (rd_hit),
    .clr_oh  (rd_clr_oh),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/msi_doorbell_bank_chk.sv
module msi_doorbell_bank_chk #(
  parameter int NREG = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_en,
  input logic            rd_hit,
  input logic [NREG-1:0] db_set_oh,
  input logic [NREG-1:0] rd_clr_oh,
  input logic [NREG-1:0] irq,
  input logic [31:0]     rd_data
);
  // R1
  reset_irq_low_chk: assert property (@(posedge clk) !rst_n |=> (irq == '0));

  // R7
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (db_set_oh != '0) |=> ((irq & $past(db_set_oh)) == $past(db_set_oh)));

  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_clr_oh != '0) && ((rd_clr_oh & db_set_oh) == '0)) |=> ((irq & $past(rd_clr_oh)) == '0));

  // R6
  collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_clr_oh & db_set_oh) != '0) |=> ((irq & $past(rd_clr_oh)) == $past(rd_clr_oh)));

  // R3
  irq_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~$past(irq) & ~$past(db_set_oh)) == '0));

  // R10
  rd_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_hit) |=> (rd_data == 32'd0));

  // R10
  miss_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (rd_clr_oh == '0));
endmodule

bind msi_doorbell_bank msi_doorbell_bank_chk #(.NREG(NREG)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_en     (rd_en),
  .rd_hit    (rd_hit),
  .db_set_oh (db_set_oh),
  .rd_clr_oh (rd_clr_oh),
  .irq       (irq),
  .rd_data   (rd_data)
);

// File: tb/msi_doorbell_bank_tb_top.sv
`timescale 1ns/1ps
module msi_doorbell_bank_tb_top;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // default layout, eight registers
  logic          w_en = 0, r_en = 0;
  logic [AW-1:0] w_addr = 0, r_addr = 0;
  logic [31:0]   w_data = 0, r_data;
  logic [7:0]    irq_d;

  // narrow layout, four registers
  logic          nw_en = 0, nr_en = 0;
  logic [AW-1:0] nw_addr = 0, nr_addr = 0;
  logic [31:0]   nw_data = 0, nr_data;
  logic [3:0]    irq_n;

  int checks = 0;
  int fails  = 0;

  msi_doorbell_bank #(.SHIFT(3), .NARROW(1'b0), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(w_en), .wr_addr(w_addr), .wr_data(w_data),
    .rd_en(r_en), .rd_addr(r_addr), .rd_data(r_data), .irq(irq_d));

  msi_doorbell_bank #(.SHIFT(2), .NARROW(1'b1), .AW(AW)) dut_n (
    .clk(clk), .rst_n(rst_n), .wr_en(nw_en), .wr_addr(nw_addr), .wr_data(nw_data),
    .rd_en(nr_en), .rd_addr(nr_addr), .rd_data(nr_data), .irq(irq_n));

  // expected bus word for one pending position, computed byte by byte
  function automatic logic [31:0] exp_word(bit nar, int n, int p);
    logic [31:0] raw, out;
    int b;
    b   = nar ? (8 * (3 - n) + 7 - p) : (31 - p);
    raw = 32'h1 << b;
    for (int k = 0; k < 4; k++) out[8*k +: 8] = raw[8*(3-k) +: 8];
    return out;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ring(bit nar, logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    if (nar) begin nw_en = 1; nw_addr = a; nw_data = d; end
    else     begin w_en = 1;  w_addr = a;  w_data = d;  end
    @(negedge clk);
    nw_en = 0; w_en = 0;
  endtask

  task automatic rd(bit nar, logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk);
    if (nar) nr_en = 1; else r_en = 1;
    if (nar) nr_addr = a; else r_addr = a;
    @(negedge clk);
    nr_en = 0; r_en = 0;
    v = nar ? nr_data : r_data;
  endtask

  task automatic t_reset();
    check("R1 irq default", 32'(irq_d), 32'd0);
    check("R1 irq narrow", 32'(irq_n), 32'd0);
    check("R1 rd_data", r_data, 32'd0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    ring(0, 0, (32'd0 << 3) | 32'd5);                 // reg 5, pos 0
    check("R7 irq rises", 32'(irq_d), 32'h20);
    rd(0, 8'h04 + 8'd20, v);
    check("R2 R4 pos0 in msb", v, exp_word(0, 5, 0));
    check("R7 irq falls", 32'(irq_d), 32'd0);
    rd(0, 8'h18, v);
    check("R5 cleared", v, 32'd0);
    ring(0, 0, (32'd31 << 3) | 32'd0);                // reg 0, pos 31
    rd(0, 8'h04, v);
    check("R2 R4 pos31 in lsb", v, exp_word(0, 0, 31));
  endtask

  task automatic t_accumulate();
    logic [31:0] v;
    ring(0, 0, (32'd3 << 3) | 32'd2);
    ring(0, 0, (32'd31 << 3) | 32'd2);
    ring(0, 0, (32'd7 << 3) | 32'd6);
    check("R9 irq two regs", 32'(irq_d), 32'h44);
    rd(0, 8'h04 + 8'd8, v);
    check("R9 OR within reg", v, exp_word(0, 2, 3) | exp_word(0, 2, 31));
    check("R9 other reg kept", 32'(irq_d), 32'h40);
    rd(0, 8'h04 + 8'd24, v);
    check("R9 reg6", v, exp_word(0, 6, 7));
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    ring(0, 0, (32'd32 << 3) | 32'd1);                // position past range
    check("R3 bad pos no irq", 32'(irq_d), 32'd0);
    ring(0, 8'h08, (32'd0 << 3) | 32'd1);             // write to a status address
    check("R10 stray write no irq", 32'(irq_d), 32'd0);
    rd(0, 8'h08, v);
    check("R3 R10 reg1 empty", v, 32'd0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    ring(0, 0, (32'd1 << 3) | 32'd0);
    @(negedge clk);
    r_en = 1; r_addr = 8'h04; w_en = 1; w_addr = 0; w_data = (32'd2 << 3) | 32'd0;
    @(negedge clk);
    r_en = 0; w_en = 0;
    check("R6 read excludes new bit", r_data, exp_word(0, 0, 1));
    check("R6 irq stays", 32'(irq_d), 32'h01);
    rd(0, 8'h04, v);
    check("R6 new bit pending", v, exp_word(0, 0, 2));
  endtask

  task automatic t_misses();
    logic [31:0] v;
    ring(0, 0, (32'd4 << 3) | 32'd3);
    rd(0, 8'h00, v);
    check("R10 doorbell reads 0", v, 32'd0);
    rd(0, 8'h11, v);
    check("R10 unaligned reads 0", v, 32'd0);
    rd(0, 8'h24, v);
    check("R10 past end reads 0", v, 32'd0);
    check("R10 misses clear nothing", 32'(irq_d), 32'h08);
    rd(0, 8'h10, v);
    check("R10 reg3 intact", v, exp_word(0, 3, 4));
  endtask

  task automatic t_narrow();
    logic [31:0] v;
    ring(1, 0, (32'd0 << 2) | 32'd1);
    check("R7 narrow irq", 32'(irq_n), 32'h2);
    rd(1, 8'h14, v);
    check("R8 R4 narrow reg1 pos0", v, exp_word(1, 1, 0));
    ring(1, 0, (32'd7 << 2) | 32'd3);
    ring(1, 0, (32'd0 << 2) | 32'd0);
    rd(1, 8'h1C, v);
    check("R8 narrow reg3 pos7", v, exp_word(1, 3, 7));
    rd(1, 8'h10, v);
    check("R8 narrow reg0 pos0", v, exp_word(1, 0, 0));
    ring(1, 0, (32'd8 << 2) | 32'd2);
    check("R3 narrow pos8 ignored", 32'(irq_n), 32'd0);
    rd(1, 8'h04, v);
    check("R4 old base not mapped", v, 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_basic();
    t_accumulate();
    t_ignore();
    t_collide();
    t_misses();
    t_narrow();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule